// File: doc/BRIEF.md
# Variable-Precision Mantissa Multiplier

This block multiplies two unsigned multi-word mantissas. Each has n words of W bits (W defaults to 64), and n is given with each start request, from 1 up to a build-time maximum of 64. A single W-by-W multiplier is reused across many cycles, one word pair at a time. Operand A words are held in the outer loop and operand B words in the inner loop. The double-width product of each pair is folded into the running result in the same two-cycle step that forms it. No partial product is kept for later summation, so the only intermediate storage is the 2n-word result memory itself.

The operand memories and the result memory sit outside the block. The block supplies word addresses for both operands and reads their data combinationally. It drives one address for the result memory: a combinational read of that word, and a write at the next clock edge when the write enable is high. Before accumulating, the block zeroes the first 2n result words. A carry from the upper word of a product step is rippled upward, one word per cycle, before the next word pair is taken. The exponent of the product is formed beside the mantissa path as the plain sum of the two operand exponents.

Top module: `vpmul_top`

## Requirements
- R1: When done is signalled, result words 0 to 2n-1 hold the full 2n-word product of A and B. Word 0 is the least significant word in the operands and in the result, and the result is exact for every operand value, including all-ones.
- R2: The word count n is taken from the start request at run time, and every value from 1 to MAX_WORDS (64) gives a correct product.
- R3: The block writes only result addresses below 2n, and it writes only while busy. Result words at addresses 2n and above keep their previous contents.
- R4: The first 2n result words are cleared before accumulation, so stale contents of the result memory never reach the product.
- R5: An accepted start latches exp_o = exp_a_i + exp_b_i as an unsigned sum one bit wider than the inputs, visible from the first busy cycle. The value holds until the next accepted start.
- R6: Each word-pair step writes the low product half into word i+j and the high half into word i+j+1. A carry out of word i+j+1 is propagated through the following words before the next pair, and propagation is entered only after a carry.
- R7: busy_o rises in the cycle after an accepted start. done_o is high for exactly one cycle, right after the last result write, with busy_o low.
- R8: A start request while busy_o is high is ignored: no error is raised, and the running product, its word count and its exponent are unchanged.
- R9: A start request while idle with n = 0 or n > MAX_WORDS raises err_o for one cycle after the request. busy_o stays low, no result word is written, and exp_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| nwords_i | input | 7 | Word count n of both operands |
| exp_a_i | input | 16 | Exponent of operand A |
| exp_b_i | input | 16 | Exponent of operand B |
| a_addr_o | output | 6 | Word address into operand A memory |
| a_data_i | input | 64 | Operand A word at a_addr_o (combinational read) |
| b_addr_o | output | 6 | Word address into operand B memory |
| b_data_i | input | 64 | Operand B word at b_addr_o (combinational read) |
| r_addr_o | output | 7 | Result memory word address, shared by read and write |
| r_rd_data_i | input | 64 | Result word at r_addr_o (combinational read) |
| r_we_o | output | 1 | Result write enable, write at the next rising edge |
| r_wr_data_o | output | 64 | Result word to write |
| exp_o | output | 17 | Latched exponent sum |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a rejected word count |

## Verification
Any single wrong word-pair step or lost carry corrupts at least one result word. Since every result word is compared against an independently computed column-sum product once done_o rises, such an error shows up within the same operation. An all-ones operand set drives the longest carry ripples, and a one-word multiplier isolates the placement of low and high halves. A clear sequence that ran too short, or a write that strayed beyond 2n, leaves a marker pattern in the result memory that the bench reads straight after completion. Control faults surface within a cycle: an accepted request that should have been ignored, a missing error pulse, or a done pulse of the wrong length appears on busy_o, err_o or done_o at the next sampling point.

// File: rtl/vpmul_pkg.sv
package vpmul_pkg;

  // Sequencer phases of the word-serial multiply
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_MLO   = 3'd2,
    ST_MHI   = 3'd3,
    ST_PROP  = 3'd4,
    ST_DONE  = 3'd5
  } vp_state_e;

endpackage

// File: rtl/vpmul_ctrl.sv
module vpmul_ctrl
  import vpmul_pkg::*;
#(
  parameter int MAXN = 64,
  parameter int NW   = 7,
  parameter int IW   = 6,
  parameter int RW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [NW-1:0] nwords_i,
  input  logic          carry_i,
  output vp_state_e     state_o,
  output logic [NW-1:0] n_o,
  output logic [IW-1:0] a_idx_o,
  output logic [IW-1:0] b_idx_o,
  output logic [RW-1:0] r_addr_o,
  output logic          r_we_o,
  output logic          accept_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int PW = RW + 1;

  vp_state_e     st_q, st_d;
  logic [NW-1:0] n_q;
  logic [IW-1:0] i_q, i_d, j_q, j_d;
  logic [PW-1:0] k_q, k_d;
  logic          err_q;

  logic          n_ok, reject_w;
  logic [PW-1:0] two_n, ij, addr;
  logic          last_i, last_j;
  vp_state_e     adv_st;
  logic [IW-1:0] adv_i, adv_j;

  assign n_ok     = (nwords_i != '0) && (int'(nwords_i) <= MAXN);
  assign accept_o = start_i && (st_q == ST_IDLE) && n_ok;
  assign reject_w = start_i && (st_q == ST_IDLE) && !n_ok;

  assign two_n  = PW'(n_q) + PW'(n_q);
  assign ij     = PW'(i_q) + PW'(j_q);
  assign last_i = (NW'(i_q) == (n_q - NW'(1)));
  assign last_j = (NW'(j_q) == (n_q - NW'(1)));

  // Where the loop goes once a word pair (and its carry ripple) is finished
  always_comb begin
    adv_i  = i_q;
    adv_j  = j_q;
    adv_st = ST_MLO;
    if (last_j) begin
      adv_j = '0;
      if (last_i) adv_st = ST_DONE;
      else        adv_i  = i_q + IW'(1);
    end else begin
      adv_j = j_q + IW'(1);
    end
  end

  always_comb begin
    st_d   = st_q;
    i_d    = i_q;
    j_d    = j_q;
    k_d    = k_q;
    r_we_o = 1'b0;
    addr   = '0;
    case (st_q)
      ST_IDLE: begin
        if (accept_o) begin
          st_d = ST_CLEAR;
          k_d  = '0;
        end
      end
      ST_CLEAR: begin
        r_we_o = 1'b1;
        addr   = k_q;
        if (k_q == two_n - PW'(1)) begin
          st_d = ST_MLO;
          i_d  = '0;
          j_d  = '0;
        end else begin
          k_d = k_q + PW'(1);
        end
      end
      ST_MLO: begin
        r_we_o = 1'b1;
        addr   = ij;
        st_d   = ST_MHI;
      end
      ST_MHI: begin
        r_we_o = 1'b1;
        addr   = ij + PW'(1);
        if (carry_i && ((ij + PW'(2)) < two_n)) begin
          st_d = ST_PROP;
          k_d  = ij + PW'(2);
        end else begin
          st_d = adv_st;
          i_d  = adv_i;
          j_d  = adv_j;
        end
      end
      ST_PROP: begin
        r_we_o = 1'b1;
        addr   = k_q;
        if (carry_i && ((k_q + PW'(1)) < two_n)) begin
          k_d = k_q + PW'(1);
        end else begin
          st_d = adv_st;
          i_d  = adv_i;
          j_d  = adv_j;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      n_q   <= '0;
      i_q   <= '0;
      j_q   <= '0;
      k_q   <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      i_q   <= i_d;
      j_q   <= j_d;
      k_q   <= k_d;
      err_q <= reject_w;
      if (accept_o) n_q <= nwords_i;
    end
  end

  assign state_o  = st_q;
  assign n_o      = n_q;
  assign a_idx_o  = i_q;
  assign b_idx_o  = j_q;
  assign r_addr_o = addr[RW-1:0];
  assign busy_o   = (st_q == ST_CLEAR) || (st_q == ST_MLO) ||
                    (st_q == ST_MHI)   || (st_q == ST_PROP);
  assign done_o   = (st_q == ST_DONE);
  assign err_o    = err_q;

endmodule

// File: rtl/vpmul_acc.sv
module vpmul_acc
  import vpmul_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  vp_state_e    state_i,
  input  logic [W-1:0] a_data_i,
  input  logic [W-1:0] b_data_i,
  input  logic [W-1:0] r_data_i,
  output logic [W-1:0] wr_data_o,
  output logic         carry_o
);

  // Full double-width product of two words
  function automatic logic [2*W-1:0] word_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    return (2*W)'(x) * (2*W)'(y);
  endfunction

  // Word add with carry in; the top bit of the result is the carry out
  function automatic logic [W:0] word_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic cin);
    return (W+1)'(x) + (W+1)'(y) + (W+1)'(cin);
  endfunction

  logic [2*W-1:0] prod_w;
  logic [W:0]     sum_w;
  logic [W-1:0]   hi_q;
  logic           c_q;

  assign prod_w = word_mul(a_data_i, b_data_i);

  always_comb begin
    case (state_i)
      ST_MLO:  sum_w = word_add(r_data_i, prod_w[W-1:0], 1'b0);
      ST_MHI:  sum_w = word_add(r_data_i, hi_q, c_q);
      ST_PROP: sum_w = word_add(r_data_i, '0, c_q);
      default: sum_w = '0;
    endcase
  end

  assign wr_data_o = sum_w[W-1:0];
  assign carry_o   = sum_w[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      c_q  <= 1'b0;
    end else begin
      case (state_i)
        ST_MLO: begin
          hi_q <= prod_w[2*W-1:W];
          c_q  <= sum_w[W];
        end
        ST_MHI, ST_PROP: c_q <= sum_w[W];
        default: c_q <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/vpmul_exp.sv
module vpmul_exp #(
  parameter int EW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [EW-1:0] exp_a_i,
  input  logic [EW-1:0] exp_b_i,
  output logic [EW:0]   exp_o
);

  function automatic logic [EW:0] exp_sum(input logic [EW-1:0] x, input logic [EW-1:0] y);
    return (EW+1)'(x) + (EW+1)'(y);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      exp_o <= '0;
    else if (load_i) exp_o <= exp_sum(exp_a_i, exp_b_i);
  end

endmodule

// File: rtl/vpmul_top.sv
module vpmul_top
  import vpmul_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int MAX_WORDS = 64,
  parameter int EXP_W     = 16,
  localparam int NW = $clog2(MAX_WORDS + 1),
  localparam int IW = $clog2(MAX_WORDS),
  localparam int RW = $clog2(2 * MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NW-1:0]     nwords_i,
  input  logic [EXP_W-1:0]  exp_a_i,
  input  logic [EXP_W-1:0]  exp_b_i,
  output logic [IW-1:0]     a_addr_o,
  input  logic [WORD_W-1:0] a_data_i,
  output logic [IW-1:0]     b_addr_o,
  input  logic [WORD_W-1:0] b_data_i,
  output logic [RW-1:0]     r_addr_o,
  input  logic [WORD_W-1:0] r_rd_data_i,
  output logic              r_we_o,
  output logic [WORD_W-1:0] r_wr_data_o,
  output logic [EXP_W:0]    exp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  // Named internal events, observed by the bound checker
  vp_state_e     state_w;
  logic          carry_w;
  logic          accept_w;
  logic [NW-1:0] n_w;

  vpmul_ctrl #(
    .MAXN(MAX_WORDS), .NW(NW), .IW(IW), .RW(RW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .nwords_i (nwords_i),
    .carry_i  (carry_w),
    .state_o  (state_w),
    .n_o      (n_w),
    .a_idx_o  (a_addr_o),
    .b_idx_o  (b_addr_o),
    .r_addr_o (r_addr_o),
    .r_we_o   (r_we_o),
    .accept_o (accept_w),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  vpmul_acc #(.W(WORD_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_i   (state_w),
    .a_data_i  (a_data_i),
    .b_data_i  (b_data_i),
    .r_data_i  (r_rd_data_i),
    .wr_data_o (r_wr_data_o),
    .carry_o   (carry_w)
  );

  vpmul_exp #(.EW(EXP_W)) u_exp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept_w),
    .exp_a_i (exp_a_i),
    .exp_b_i (exp_b_i),
    .exp_o   (exp_o)
  );

endmodule

// File: rtl/vpmul_chk.sv
module vpmul_chk
  import vpmul_pkg::*;
#(
  parameter int NW = 7,
  parameter int RW = 7,
  parameter int EW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          r_we_o,
  input logic [RW-1:0] r_addr_o,
  input logic [NW-1:0] n_q,
  input logic [EW-1:0] exp_a_i,
  input logic [EW-1:0] exp_b_i,
  input logic [EW:0]   exp_o,
  input vp_state_e     state,
  input logic          carry
);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_write_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    r_we_o |-> ((32'(r_addr_o)) < (2 * 32'(n_q))));

  p_write_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    r_we_o |-> busy_o);

  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (!err_o && $stable(n_q)));

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !r_we_o));

  p_exp_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (exp_o == ((EW+1)'($past(exp_a_i)) + (EW+1)'($past(exp_b_i)))));

  p_exp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(exp_o));

  p_prop_after_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROP) |-> $past(carry));

endmodule

bind vpmul_top vpmul_chk #(.NW(NW), .RW(RW), .EW(EXP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .r_we_o   (r_we_o),
  .r_addr_o (r_addr_o),
  .n_q      (n_w),
  .exp_a_i  (exp_a_i),
  .exp_b_i  (exp_b_i),
  .exp_o    (exp_o),
  .state    (state_w),
  .carry    (carry_w)
);

// File: tb/vpmul_top_tb.sv
`timescale 1ns/1ps
module vpmul_top_tb;
  localparam int W    = 64;
  localparam int MAXN = 64;
  localparam int EW   = 16;
  localparam int NW   = $clog2(MAXN + 1);
  localparam int IW   = $clog2(MAXN);
  localparam int RW   = $clog2(2 * MAXN);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [NW-1:0] nwords_i = '0;
  logic [EW-1:0] exp_a_i = '0, exp_b_i = '0;
  logic [IW-1:0] a_addr, b_addr;
  logic [W-1:0]  a_data, b_data, r_rd, r_wd;
  logic [RW-1:0] r_addr;
  logic          r_we, busy, done, err;
  logic [EW:0]   exp_o;

  logic [W-1:0] mem_a [MAXN];
  logic [W-1:0] mem_b [MAXN];
  logic [W-1:0] mem_r [2*MAXN];
  logic [W-1:0] ref_r [2*MAXN];

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vpmul_top #(.WORD_W(W), .MAX_WORDS(MAXN), .EXP_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nwords_i(nwords_i),
    .exp_a_i(exp_a_i), .exp_b_i(exp_b_i),
    .a_addr_o(a_addr), .a_data_i(a_data), .b_addr_o(b_addr), .b_data_i(b_data),
    .r_addr_o(r_addr), .r_rd_data_i(r_rd), .r_we_o(r_we), .r_wr_data_o(r_wd),
    .exp_o(exp_o), .busy_o(busy), .done_o(done), .err_o(err)
  );

  assign a_data = mem_a[a_addr];
  assign b_data = mem_b[b_addr];
  assign r_rd   = mem_r[r_addr];
  always @(posedge clk) if (r_we) mem_r[r_addr] <= r_wd;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] marker(input int k);
    return 64'hA5A5_C3C3_0000_0000 | 64'(k);
  endfunction

  // pattern 0: random, 1: all ones, 2: A random times B = 1
  task automatic fill(input int n, input int pat);
    for (int k = 0; k < MAXN; k++) begin
      mem_a[k] = {$urandom, $urandom};
      mem_b[k] = {$urandom, $urandom};
      if (k < n && pat == 1) begin
        mem_a[k] = '1;
        mem_b[k] = '1;
      end
      if (pat == 2) mem_b[k] = (k == 0) ? 64'd1 : 64'd0;
    end
    for (int k = 0; k < 2*MAXN; k++) mem_r[k] = marker(k);
  endtask

  // Column-by-column reference product, wide accumulator
  task automatic compute_ref(input int n);
    logic [135:0] acc;
    acc = '0;
    for (int c = 0; c < 2*n - 1; c++) begin
      for (int i = 0; i < n; i++) begin
        int j;
        j = c - i;
        if (j >= 0 && j < n)
          acc = acc + 136'(128'(mem_a[i]) * 128'(mem_b[j]));
      end
      ref_r[c] = acc[63:0];
      acc = acc >> 64;
    end
    ref_r[2*n-1] = acc[63:0];
  endtask

  task automatic pulse_start(input int n, input logic [EW-1:0] ea, input logic [EW-1:0] eb);
    @(negedge clk);
    start_i  = 1'b1;
    nwords_i = NW'(n);
    exp_a_i  = ea;
    exp_b_i  = eb;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 150000; c++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_result(input int n, input string req);
    for (int k = 0; k < 2*n; k++)
      chk(mem_r[k] === ref_r[k], req, $sformatf("result word %0d", k), 128'(mem_r[k]), 128'(ref_r[k]));
    for (int k = 2*n; k < 2*MAXN; k++)
      if (mem_r[k] !== marker(k))
        chk(1'b0, "R3", $sformatf("word %0d above 2n", k), 128'(mem_r[k]), 128'(marker(k)));
    chk(1'b1, "R3", "upper words untouched", 0, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !r_we, "R7", "reset outputs quiet",
        128'({busy, done, err, r_we}), 0);
    chk(exp_o == '0, "R5", "reset exponent", 128'(exp_o), 0);
  endtask

  task automatic t_mul(input string req, input int n, input int pat);
    bit seen;
    logic [EW-1:0] ea, eb;
    logic [EW:0] ex;
    ea = 16'($urandom); eb = 16'($urandom);
    ex = (EW+1)'(ea) + (EW+1)'(eb);
    fill(n, pat);
    compute_ref(n);
    pulse_start(n, ea, eb);
    chk(busy == 1'b1, "R7", $sformatf("busy after start n=%0d", n), 128'(busy), 1);
    chk(exp_o == ex, "R5", "exponent sum", 128'(exp_o), 128'(ex));
    wait_done(seen);
    chk(seen, "R7", "done reached", 128'(seen), 1);
    chk(!busy, "R7", "busy low with done", 128'(busy), 0);
    check_result(n, req);
    @(negedge clk);
    chk(!done, "R7", "done one cycle", 128'(done), 0);
    chk(exp_o == ex, "R5", "exponent held", 128'(exp_o), 128'(ex));
  endtask

  task automatic t_busy_start();
    bit seen;
    logic [EW:0] ex;
    fill(5, 0);
    compute_ref(5);
    ex = (EW+1)'(16'h1234) + (EW+1)'(16'h0101);
    pulse_start(5, 16'h1234, 16'h0101);
    repeat (10) @(negedge clk);
    pulse_start(2, 16'h7777, 16'h7777);
    chk(!err, "R8", "no error for start while busy", 128'(err), 0);
    chk(exp_o == ex, "R8", "exponent kept while busy", 128'(exp_o), 128'(ex));
    wait_done(seen);
    chk(seen, "R8", "done reached", 128'(seen), 1);
    check_result(5, "R8");
    @(negedge clk);
    chk(!busy, "R8", "no restart after done", 128'(busy), 0);
  endtask

  task automatic t_bad_n(input int n);
    logic [EW:0] ex;
    logic [W-1:0] snap [2*MAXN];
    ex = exp_o;
    for (int k = 0; k < 2*MAXN; k++) snap[k] = mem_r[k];
    pulse_start(n, 16'hFFFF, 16'h0001);
    chk(err == 1'b1, "R9", $sformatf("error pulse n=%0d", n), 128'(err), 1);
    chk(!busy, "R9", "stays idle", 128'(busy), 0);
    @(negedge clk);
    chk(!err, "R9", "error one cycle", 128'(err), 0);
    chk(!busy, "R9", "still idle", 128'(busy), 0);
    chk(exp_o == ex, "R9", "exponent unchanged", 128'(exp_o), 128'(ex));
    for (int k = 0; k < 2*MAXN; k++)
      if (mem_r[k] !== snap[k])
        chk(1'b0, "R9", $sformatf("word %0d written", k), 128'(mem_r[k]), 128'(snap[k]));
    chk(1'b1, "R9", "memory untouched", 0, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 2*MAXN; k++) mem_r[k] = '0;
    for (int k = 0; k < MAXN; k++) begin
      mem_a[k] = '0;
      mem_b[k] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mul("R1", 1, 0);   // single word
    t_mul("R6", 1, 1);   // low/high placement with maximal carry
    t_mul("R4", 3, 0);   // stale result memory must be cleared
    t_mul("R6", 4, 1);   // long carry ripples
    t_mul("R1", 6, 2);   // multiply by one
    t_mul("R1", 8, 0);
    t_mul("R6", 16, 1);
    t_mul("R2", 64, 0);  // largest word count
    t_busy_start();
    t_bad_n(0);
    t_bad_n(65);
    t_bad_n(127);
    t_mul("R2", 2, 0);   // normal operation after rejects
    summary();
    $finish;
  end

endmodule